// File: doc/BRIEF.md
# Flash Toggle-Bit Status Poller

This block runs on the host side of a parallel NOR flash and decides whether an embedded program or erase has finished. After a start pulse it issues status reads in pairs to one address through a request/acknowledge port, which feeds a separate bus-cycle engine. In each pair it compares the toggle flag from the first read with the one from the second. When the flag holds still, the operation is over and the poller reports a pass. When the flag keeps changing, the poller reads again. If the timeout flag shows up, the poller runs one more confirming pair before it gives a verdict, because the toggle flag may have settled just as the timeout flag rose.

If the operation failed, the poller writes the reset command to the polled address, which returns the device to array read, and then raises a fail flag. The fail flag stays up until the next start. An optional watchdog turns a run that keeps toggling into a failure once it has seen a programmable number of pairs. An abort input drops whatever is in progress. The next start then begins with a fresh first read and keeps no earlier verdict state.

Top module: `flash_poll_ctrl`

## Requirements
- R1: A start pulse seen while idle latches the address, raises busy on the next cycle and requests a status read (write flag 0) of that address. A start pulse while busy is ignored.
- R2: The toggle flag is status bit 6. If the second read of a pair returns the same bit 6 as the first, the poller pulses done and pass together, then goes idle with no request pending.
- R3: If bit 6 differs within a pair and the timeout flag (status bit 5) of the second read is 0, a new pair begins with a read and nothing is reported.
- R4: If bit 6 differs and the second read has bit 5 set, one confirming pair follows. If bit 6 is equal within that pair, the result is a pass.
- R5: If bit 6 still differs within the confirming pair, the next request is a write of data 0xF0 to the polled address. Done pulses, with fail set, in the cycle after that write is acknowledged.
- R6: The fail flag stays set until the next start is accepted, and it is cleared in the cycle after that start.
- R7: Abort while busy returns the poller to idle on the next cycle with no request and no done. Abort takes priority over an acknowledge in the same cycle. A pending confirming pair is forgotten, so the next start behaves as a fresh run.
- R8: When `max_pairs_i` is nonzero, the pair that brings the count of toggling pairs with bit 5 clear up to `max_pairs_i` leads to the reset write and a fail. A value of 0 turns the watchdog off.
- R9: A request stays asserted with a stable address, write flag and data until it is acknowledged. Done pulses for exactly one cycle, the cycle after the acknowledge that ends the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a status check |
| addr_i | input | ADDR_W | Address to poll, latched on start |
| max_pairs_i | input | PAIR_CNT_W | Watchdog pair limit, 0 disables |
| abort_i | input | 1 | Abandon the run and return to idle |
| req_valid_o | output | 1 | Bus transaction request |
| req_write_o | output | 1 | 1 for write, 0 for read |
| req_addr_o | output | ADDR_W | Transaction address |
| req_wdata_o | output | DATA_W | Write data (reset command) |
| req_ack_i | input | 1 | Transaction complete |
| rsp_data_i | input | DATA_W | Status byte, valid with acknowledge |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | Pulses with done on success |
| fail_o | output | 1 | Failure flag, held until next start |

## Verification
Every verdict is registered. Done, pass and fail appear in the cycle right after the edge that samples the last acknowledge. The next request shows up in that same cycle, because the request outputs decode the state register directly. Busy rises, and the first read request appears, one cycle after start. Abort clears busy and the request one cycle after it is applied. The bench drives each acknowledge for a single cycle from a falling edge and then samples every output at the next falling edge, which is the cycle where each of these results falls due.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RD1  = 2'd1,
      ST_RD2  = 2'd2,
      ST_RST  = 2'd3
   } poll_state_t;

   typedef enum logic [1:0] {
      V_PASS  = 2'd0,
      V_AGAIN = 2'd1,
      V_ARM   = 2'd2,
      V_FAIL  = 2'd3
   } verdict_t;

endpackage

// File: rtl/flash_poll_cmp.sv
module flash_poll_cmp
   import flash_poll_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int TOG_POS = 6,
   parameter int TMO_POS = 5
) (
   input  logic              first_bit_i,
   input  logic [DATA_W-1:0] status_i,
   input  logic              recheck_i,
   output verdict_t          verdict_o
);

   logic same_w;
   logic tmo_w;

   assign same_w = (first_bit_i == status_i[TOG_POS]);
   assign tmo_w  = status_i[TMO_POS];

   always_comb begin
      if (same_w)
         verdict_o = V_PASS;
      else if (recheck_i)
         verdict_o = V_FAIL;
      else if (tmo_w)
         verdict_o = V_ARM;
      else
         verdict_o = V_AGAIN;
   end

endmodule

// File: rtl/flash_poll_wdog.sv
module flash_poll_wdog #(
   parameter int CNT_W   = 16,
   parameter bit WDOG_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             inc_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             last_o
);

   generate
      if (WDOG_EN) begin : g_wdog
         logic [CNT_W-1:0] cnt_q;
         logic [CNT_W:0]   cnt_nx;

         assign cnt_nx = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
         assign last_o = (limit_i != '0) && (cnt_nx >= {1'b0, limit_i});

         always_ff @(posedge clk) begin
            if (!rst_n || clr_i)
               cnt_q <= '0;
            else if (inc_i && !cnt_nx[CNT_W])
               cnt_q <= cnt_nx[CNT_W-1:0];
         end
      end else begin : g_nowdog
         logic unused_wdog;
         assign unused_wdog = ^{clk, rst_n, clr_i, inc_i, limit_i};
         assign last_o = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/flash_poll_req.sv
module flash_poll_req
   import flash_poll_pkg::*;
#(
   parameter int          DATA_W    = 8,
   parameter int          ADDR_W    = 24,
   parameter logic [7:0]  RESET_CMD = 8'hF0
) (
   input  poll_state_t       state_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              valid_o,
   output logic              write_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] wdata_o
);

   localparam int CMD_W = (DATA_W < 8) ? DATA_W : 8;

   always_comb begin
      valid_o = (state_i != ST_IDLE);
      write_o = (state_i == ST_RST);
      addr_o  = addr_i;
      wdata_o = '0;
      if (state_i == ST_RST)
         wdata_o[CMD_W-1:0] = RESET_CMD[CMD_W-1:0];
   end

endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
   import flash_poll_pkg::*;
#(
   parameter int         DATA_W     = 8,
   parameter int         ADDR_W     = 24,
   parameter int         PAIR_CNT_W = 16,
   parameter int         TOG_POS    = 6,
   parameter int         TMO_POS    = 5,
   parameter bit         WDOG_EN    = 1'b1,
   parameter logic [7:0] RESET_CMD  = 8'hF0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic [ADDR_W-1:0]     addr_i,
   input  logic [PAIR_CNT_W-1:0] max_pairs_i,
   input  logic                  abort_i,
   output logic                  req_valid_o,
   output logic                  req_write_o,
   output logic [ADDR_W-1:0]     req_addr_o,
   output logic [DATA_W-1:0]     req_wdata_o,
   input  logic                  req_ack_i,
   input  logic [DATA_W-1:0]     rsp_data_i,
   output logic                  busy_o,
   output logic                  done_o,
   output logic                  pass_o,
   output logic                  fail_o
);

   generate
      if (TOG_POS >= DATA_W || TMO_POS >= DATA_W || TOG_POS == TMO_POS)
         $error("flash_poll_ctrl: flag positions out of range or equal");
      if (ADDR_W < 1 || PAIR_CNT_W < 1 || DATA_W < 2)
         $error("flash_poll_ctrl: widths too small");
   endgenerate

   poll_state_t       state_q;
   logic [ADDR_W-1:0] addr_q;
   logic              first_q;
   logic              recheck_q;
   logic              fail_q;
   logic              done_q;
   logic              pass_q;

   verdict_t          verdict_w;
   logic              wdog_last_w;
   logic              accept_w;
   logic              pair_end_w;
   logic              kill_w;
   logic              unused_rsp;

   assign unused_rsp = ^rsp_data_i;
   assign kill_w     = abort_i && (state_q != ST_IDLE);
   assign accept_w   = (state_q == ST_IDLE) && start_i;
   assign pair_end_w = (state_q == ST_RD2) && req_ack_i && !kill_w;

   flash_poll_cmp #(
      .DATA_W  (DATA_W),
      .TOG_POS (TOG_POS),
      .TMO_POS (TMO_POS)
   ) i_cmp (
      .first_bit_i (first_q),
      .status_i    (rsp_data_i),
      .recheck_i   (recheck_q),
      .verdict_o   (verdict_w)
   );

   flash_poll_wdog #(
      .CNT_W   (PAIR_CNT_W),
      .WDOG_EN (WDOG_EN)
   ) i_wdog (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (accept_w),
      .inc_i   (pair_end_w && (verdict_w == V_AGAIN)),
      .limit_i (max_pairs_i),
      .last_o  (wdog_last_w)
   );

   flash_poll_req #(
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .RESET_CMD (RESET_CMD)
   ) i_req (
      .state_i (state_q),
      .addr_i  (addr_q),
      .valid_o (req_valid_o),
      .write_o (req_write_o),
      .addr_o  (req_addr_o),
      .wdata_o (req_wdata_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         addr_q    <= '0;
         first_q   <= 1'b0;
         recheck_q <= 1'b0;
         fail_q    <= 1'b0;
         done_q    <= 1'b0;
         pass_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         pass_q <= 1'b0;
         if (kill_w) begin
            state_q   <= ST_IDLE;
            recheck_q <= 1'b0;
         end else begin
            unique case (state_q)
               ST_IDLE: begin
                  if (start_i) begin
                     state_q   <= ST_RD1;
                     addr_q    <= addr_i;
                     fail_q    <= 1'b0;
                     recheck_q <= 1'b0;
                  end
               end
               ST_RD1: begin
                  if (req_ack_i) begin
                     first_q <= rsp_data_i[TOG_POS];
                     state_q <= ST_RD2;
                  end
               end
               ST_RD2: begin
                  if (req_ack_i) begin
                     unique case (verdict_w)
                        V_PASS: begin
                           state_q <= ST_IDLE;
                           done_q  <= 1'b1;
                           pass_q  <= 1'b1;
                        end
                        V_ARM: begin
                           recheck_q <= 1'b1;
                           state_q   <= ST_RD1;
                        end
                        V_AGAIN: begin
                           state_q <= wdog_last_w ? ST_RST : ST_RD1;
                        end
                        default: begin
                           state_q <= ST_RST;
                        end
                     endcase
                  end
               end
               default: begin
                  if (req_ack_i) begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                     fail_q  <= 1'b1;
                  end
               end
            endcase
         end
      end
   end

   assign busy_o = (state_q != ST_IDLE);
   assign done_o = done_q;
   assign pass_o = pass_q;
   assign fail_o = fail_q;

endmodule

// File: rtl/flash_poll_ctrl_chk.sv
module flash_poll_ctrl_chk #(
   parameter int         DATA_W    = 8,
   parameter int         ADDR_W    = 24,
   parameter logic [7:0] RESET_CMD = 8'hF0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              abort_i,
   input logic              req_valid_o,
   input logic              req_write_o,
   input logic [ADDR_W-1:0] req_addr_o,
   input logic [DATA_W-1:0] req_wdata_o,
   input logic              req_ack_i,
   input logic              busy_o,
   input logic              done_o,
   input logic              pass_o,
   input logic              fail_o
);

   localparam int CMD_W = (DATA_W < 8) ? DATA_W : 8;

   a_r9_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_o && !req_ack_i && !abort_i |=>
         req_valid_o && $stable(req_addr_o) && $stable(req_write_o) && $stable(req_wdata_o));

   a_r5_rst_data: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_o && req_write_o |-> req_wdata_o[CMD_W-1:0] == RESET_CMD[CMD_W-1:0]);

   a_r7_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
      abort_i && busy_o |=> !busy_o && !req_valid_o && !done_o);

   a_r6_fail_hold: assert property (@(posedge clk) disable iff (!rst_n)
      fail_o && !start_i |=> fail_o);

   a_r9_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(req_valid_o && req_ack_i));

   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r2_pass_excl: assert property (@(posedge clk) disable iff (!rst_n)
      pass_o |-> done_o && !fail_o);

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !req_valid_o);

endmodule

bind flash_poll_ctrl flash_poll_ctrl_chk #(
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .RESET_CMD (RESET_CMD)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .abort_i     (abort_i),
   .req_valid_o (req_valid_o),
   .req_write_o (req_write_o),
   .req_addr_o  (req_addr_o),
   .req_wdata_o (req_wdata_o),
   .req_ack_i   (req_ack_i),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .pass_o      (pass_o),
   .fail_o      (fail_o)
);

// File: tb/test_flash_poll_ctrl.sv
module test_flash_poll_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int DW = 8;
   localparam int AW = 24;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [AW-1:0] addr_i = '0;
   logic [CW-1:0] max_pairs_i = '0;
   logic          abort_i = 1'b0;
   logic          req_valid_o, req_write_o;
   logic [AW-1:0] req_addr_o;
   logic [DW-1:0] req_wdata_o;
   logic          req_ack_i = 1'b0;
   logic [DW-1:0] rsp_data_i = '0;
   logic          busy_o, done_o, pass_o, fail_o;

   int n_checks = 0;
   int n_fail = 0;

   logic          s_wr;
   logic [DW-1:0] s_wd;
   logic [AW-1:0] s_addr;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_poll_ctrl i_flash_poll_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
      .max_pairs_i(max_pairs_i), .abort_i(abort_i),
      .req_valid_o(req_valid_o), .req_write_o(req_write_o),
      .req_addr_o(req_addr_o), .req_wdata_o(req_wdata_o),
      .req_ack_i(req_ack_i), .rsp_data_i(rsp_data_i),
      .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o), .fail_o(fail_o)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic kick(input logic [AW-1:0] a);
      addr_i = a; start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
   endtask

   // acknowledge the pending request with a status byte; returns at the
   // falling edge after the acknowledging edge
   task automatic serve(input logic [DW-1:0] st);
      for (int n = 0; n < 20 && !req_valid_o; n++) @(negedge clk);
      s_wr = req_write_o; s_wd = req_wdata_o; s_addr = req_addr_o;
      req_ack_i = 1'b1; rsp_data_i = st;
      @(negedge clk);
      req_ack_i = 1'b0; rsp_data_i = '0;
   endtask

   task automatic t_reset();
      check("R1 reset busy", busy_o, 0);
      check("R1 reset req", req_valid_o, 0);
      check("R6 reset fail", fail_o, 0);
      check("R9 reset done", done_o, 0);
   endtask

   task automatic t_quick_pass();
      kick(24'h00_1234);
      check("R1 busy after start", busy_o, 1);
      check("R1 read request", {req_valid_o, req_write_o}, 2'b10);
      check("R1 read address", req_addr_o, 24'h00_1234);
      serve(8'h40);
      check("R2 no done after first read", done_o, 0);
      serve(8'h40);
      check("R2 read in second slot", s_wr, 0);
      check("R2 done", done_o, 1);
      check("R2 pass", pass_o, 1);
      check("R2 not fail", fail_o, 0);
      check("R2 idle after pass", {busy_o, req_valid_o}, 2'b00);
      @(negedge clk);
      check("R9 done single cycle", done_o, 0);
   endtask

   task automatic t_start_ignored();
      kick(24'h00_0AAA);
      serve(8'h00);
      start_i = 1'b1; addr_i = 24'h55_5555;
      @(negedge clk); start_i = 1'b0;
      check("R1 start ignored while busy", req_addr_o, 24'h00_0AAA);
      serve(8'h00);
      check("R1 run ends normally", pass_o, 1);
      @(negedge clk);
   endtask

   task automatic t_keep_poll();
      kick(24'h00_0100);
      serve(8'h00); serve(8'h40);
      check("R3 no done on toggling", done_o, 0);
      check("R3 next request is read", {req_valid_o, req_write_o}, 2'b10);
      serve(8'h40); serve(8'h00);
      check("R3 still polling", {done_o, busy_o}, 2'b01);
      serve(8'h00); serve(8'h00);
      check("R3 pass after settling", {done_o, pass_o}, 2'b11);
      @(negedge clk);
   endtask

   task automatic t_recheck_pass();
      kick(24'h00_0200);
      serve(8'h00); serve(8'h60);
      check("R4 no verdict on timeout flag", done_o, 0);
      check("R4 confirming read", {req_valid_o, req_write_o}, 2'b10);
      serve(8'h20); serve(8'h20);
      check("R4 confirm pass", {done_o, pass_o, fail_o}, 3'b110);
      @(negedge clk);
   endtask

   task automatic t_recheck_fail();
      kick(24'h00_0300);
      serve(8'h00); serve(8'h60);
      serve(8'h20); serve(8'h60);
      check("R5 no done before reset write", done_o, 0);
      serve(8'h00);
      check("R5 reset is a write", s_wr, 1);
      check("R5 reset data", s_wd, 8'hF0);
      check("R5 reset address", s_addr, 24'h00_0300);
      check("R5 done with fail", {done_o, pass_o, fail_o}, 3'b101);
      for (int i = 0; i < 4; i++) @(negedge clk);
      check("R6 fail held", fail_o, 1);
      kick(24'h00_0301);
      check("R6 fail cleared on start", fail_o, 0);
      serve(8'h40); serve(8'h40);
      @(negedge clk);
   endtask

   task automatic t_abort();
      kick(24'h00_0400);
      serve(8'h00); serve(8'h60);
      abort_i = 1'b1; @(negedge clk); abort_i = 1'b0;
      check("R7 idle after abort", {busy_o, req_valid_o, done_o}, 3'b000);
      kick(24'h00_0400);
      serve(8'h00); serve(8'h40);
      check("R7 fresh run keeps reading", {req_valid_o, req_write_o, done_o}, 3'b100);
      // abort coinciding with an acknowledge
      req_ack_i = 1'b1; rsp_data_i = 8'h00; abort_i = 1'b1;
      @(negedge clk);
      req_ack_i = 1'b0; abort_i = 1'b0;
      check("R7 abort beats ack", {busy_o, done_o}, 2'b00);
      kick(24'h00_0401);
      serve(8'h40); serve(8'h40);
      check("R7 restart passes", pass_o, 1);
      @(negedge clk);
   endtask

   task automatic t_wdog();
      max_pairs_i = 16'd3;
      kick(24'h00_0500);
      serve(8'h00); serve(8'h40);
      serve(8'h00); serve(8'h40);
      check("R8 below limit still reading", {req_valid_o, req_write_o}, 2'b10);
      serve(8'h00); serve(8'h40);
      check("R8 limit reached gives write", {req_valid_o, req_write_o}, 2'b11);
      serve(8'h00);
      check("R8 reset data", s_wd, 8'hF0);
      check("R8 fail", {done_o, fail_o}, 2'b11);
      max_pairs_i = 16'd0;
      kick(24'h00_0501);
      for (int i = 0; i < 5; i++) begin serve(8'h00); serve(8'h40); end
      check("R8 disabled keeps polling", {busy_o, req_write_o}, 2'b10);
      serve(8'h00); serve(8'h00);
      check("R8 disabled pass", pass_o, 1);
      @(negedge clk);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            t_reset();
            t_quick_pass();
            t_start_ignored();
            t_keep_poll();
            t_recheck_pass();
            t_recheck_fail();
            t_abort();
            t_wdog();
         end
         begin
            repeat (20000) @(negedge clk);
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
         end
      join_any
      disable fork;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule